// File: doc/BRIEF.md
# Timer Interrupt Rate Divider

This block sits beside a periodic timer and thins out the interrupts that the timer would otherwise raise on every underflow. A software-programmed divide ratio `n` (1 to 15) sets how many counted underflows must pass between interrupts. The interrupt output is a pulse one clock wide, raised once for every `n`-th counted underflow.

Two counting modes exist. In the plain mode every underflow strobe is counted. In the qualified mode an underflow is counted only when a qualifying condition holds in the same cycle. A select input chooses between two conditions: the carrier is at its peak, or the carrier is at its valley. Both condition flags are inputs that are valid together with the underflow strobe.

The ratio is written through a simple write strobe with 4 bits of data. A write that is accepted reloads the internal count. A write that breaks a programming rule is dropped and flagged with a one-cycle error pulse. The rules are: no zero ratio, and in qualified mode no write while the timer runs.

Top module: `irq_decimator`

## Requirements
- R1: After a synchronous active-low reset, `irq_pulse` and `wr_err` are low and the ratio is 1. In plain mode every underflow then raises an interrupt.
- R2: In plain mode (`mode_qual`=0) every cycle with `uf_strobe`=1 is a counted event. With ratio n, `irq_pulse` is high in the cycle after every n-th counted event.
- R3: In qualified mode (`mode_qual`=1) with `cond_sel`=0 (peak), an underflow is counted only when `at_peak`=1 in the same cycle. `at_valley` has no effect.
- R4: In qualified mode with `cond_sel`=1 (valley), an underflow is counted only when `at_valley`=1 in the same cycle. `at_peak` has no effect.
- R5: An accepted write of a nonzero `wr_data` sets the ratio and clears the count. The next interrupt follows the n-th counted event after the write.
- R6: When an accepted write and a counted event fall in the same cycle, the write wins. That event is not counted and raises no interrupt.
- R7: In qualified mode, a write while `timer_running`=1 is ignored and leaves ratio and count unchanged. `wr_err` is high for one cycle after it. An event in that cycle is still counted.
- R8: A write of value 0 is ignored in either mode and leaves ratio and count unchanged. `wr_err` is high for one cycle after it.
- R9: `irq_pulse` never rises unless a counted event occurred on the previous clock edge. With no counted events it stays low.
- R10: In plain mode, a nonzero write while `timer_running`=1 is accepted, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uf_strobe | input | 1 | One-cycle timer underflow strobe |
| mode_qual | input | 1 | 0: count every underflow; 1: count qualified underflows only |
| cond_sel | input | 1 | Qualifier select: 0 peak, 1 valley |
| at_peak | input | 1 | Carrier-at-peak flag, valid with `uf_strobe` |
| at_valley | input | 1 | Carrier-at-valley flag, valid with `uf_strobe` |
| timer_running | input | 1 | Timer run status |
| wr_en | input | 1 | Ratio write strobe |
| wr_data | input | CNT_W | Ratio value to write |
| irq_pulse | output | 1 | Decimated interrupt pulse |
| wr_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
Some properties are checked by the assertions on every cycle. The count never reaches the ratio, and the stored ratio is never zero. Every interrupt traces back to a counted event on the previous edge, and an accepted write blocks the interrupt that follows it. Every rejected write leaves the ratio untouched and produces an error pulse.

Other behaviours only the bench scenarios can show. These are the exact spacing of interrupts for a given ratio and the filtering by peak or valley. The bench also shows the restart of counting after a reload, and that a write which coincides with an underflow swallows that underflow.

// File: rtl/irqd_pkg.sv
// Package: shared types for the interrupt rate divider.
// Assumes: nothing beyond a synchronous design context.
package irqd_pkg;

    // Which carrier condition qualifies an underflow in qualified mode
    typedef enum logic {
        QSEL_PEAK   = 1'b0,
        QSEL_VALLEY = 1'b1
    } qsel_e;

    // Counting mode
    typedef enum logic {
        MODE_ALL  = 1'b0,
        MODE_QUAL = 1'b1
    } cmode_e;

endpackage

// File: rtl/irqd_qualifier.sv
// Module: irqd_qualifier
// Decides whether the current underflow strobe is a counted event.
// Assumes: at_peak / at_valley are valid in the same cycle as uf_strobe.
module irqd_qualifier
    import irqd_pkg::*;
(
    input  logic uf_strobe,
    input  logic mode_qual,
    input  logic cond_sel,
    input  logic at_peak,
    input  logic at_valley,
    output logic cnt_event
);

    qsel_e  sel;
    cmode_e mode;
    logic   cond_ok;

    assign sel  = qsel_e'(cond_sel);
    assign mode = cmode_e'(mode_qual);

    // Pick the qualifying condition chosen by the select
    always_comb begin
        case (sel)
            QSEL_PEAK:   cond_ok = at_peak;
            QSEL_VALLEY: cond_ok = at_valley;
            default:     cond_ok = 1'b0;
        endcase
    end

    // Combine the strobe with the mode and the condition
    always_comb begin
        if (mode == MODE_ALL) cnt_event = uf_strobe;
        else                  cnt_event = uf_strobe & cond_ok;
    end

endmodule

// File: rtl/irqd_ratio_reg.sv
// Module: irqd_ratio_reg
// Holds the divide ratio and applies the write rules.
// Rejects zero, and rejects writes in qualified mode while the timer runs.
// Assumes: wr_en is a single-cycle strobe from the register interface.
module irqd_ratio_reg #(
    parameter int CNT_W       = 4,
    parameter int RESET_RATIO = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             mode_qual,
    input  logic             timer_running,
    output logic [CNT_W-1:0] ratio_q,
    output logic             load,
    output logic             wr_err
);

    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_RATIO);

    logic data_zero;
    logic run_block;

    assign data_zero = (wr_data == '0);
    assign run_block = mode_qual & timer_running;
    assign load      = wr_en & ~data_zero & ~run_block;

    // Store the ratio on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)    ratio_q <= RST_VAL;
        else if (load) ratio_q <= wr_data;
    end

    // Pulse the error flag for a rejected write
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en & ~load;
    end

    // R8
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q != '0);

    // R7
    run_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_qual && timer_running) |=> ($stable(ratio_q) && wr_err));

    // R8
    zero_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |=> ($stable(ratio_q) && wr_err));

endmodule

// File: rtl/irqd_counter.sv
// Module: irqd_counter
// Counts qualified events and emits one pulse each time the ratio is reached.
// A load restarts the count and swallows any event in the same cycle.
// Assumes: ratio_i is never zero.
module irqd_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic             load,
    input  logic             cnt_event,
    output logic             irq_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == ratio_i - CNT_W'(1));

    // Advance the event count, wrapping at the ratio
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= '0;
        else if (cnt_event && at_last) cnt_q <= '0;
        else if (cnt_event)           cnt_q <= cnt_q + CNT_W'(1);
    end

    // Register the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= ~load & cnt_event & at_last;
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_i);

    // R9
    irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(cnt_event));

    // R6
    load_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !irq_pulse);

endmodule

// File: rtl/irq_decimator.sv
// Module: irq_decimator (top)
// Divides timer underflows down to one interrupt per n counted events.
// Counts every underflow, or only those at the selected carrier extreme.
// Assumes: a synchronous active-low reset and single-cycle strobes.
module irq_decimator #(
    parameter int CNT_W       = 4,
    parameter int RESET_RATIO = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uf_strobe,
    input  logic             mode_qual,
    input  logic             cond_sel,
    input  logic             at_peak,
    input  logic             at_valley,
    input  logic             timer_running,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_pulse,
    output logic             wr_err
);

    logic             cnt_event;
    logic             load;
    logic [CNT_W-1:0] ratio_q;

    irqd_qualifier u_qual (
        .uf_strobe (uf_strobe),
        .mode_qual (mode_qual),
        .cond_sel  (cond_sel),
        .at_peak   (at_peak),
        .at_valley (at_valley),
        .cnt_event (cnt_event)
    );

    irqd_ratio_reg #(.CNT_W(CNT_W), .RESET_RATIO(RESET_RATIO)) u_ratio (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .mode_qual     (mode_qual),
        .timer_running (timer_running),
        .ratio_q       (ratio_q),
        .load          (load),
        .wr_err        (wr_err)
    );

    irqd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_i   (ratio_q),
        .load      (load),
        .cnt_event (cnt_event),
        .irq_pulse (irq_pulse)
    );

    // R3
    peak_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(mode_qual) && !$past(cond_sel)) |-> $past(at_peak && uf_strobe));

    // R4
    valley_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(mode_qual) && $past(cond_sel)) |-> $past(at_valley && uf_strobe));

    // R10
    plain_run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_qual && wr_data != '0) |=> !wr_err);

endmodule

// File: tb/irq_decimator_tb.sv
module irq_decimator_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         uf_strobe = 1'b0, mode_qual = 1'b0, cond_sel = 1'b0;
    logic         at_peak = 1'b0, at_valley = 1'b0, timer_running = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         irq_pulse, wr_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int m_ratio = 1;
    int m_cnt = 0;

    always #2 clk = ~clk;

    irq_decimator #(.CNT_W(W), .RESET_RATIO(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .uf_strobe(uf_strobe), .mode_qual(mode_qual),
        .cond_sel(cond_sel), .at_peak(at_peak), .at_valley(at_valley),
        .timer_running(timer_running), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pulse(irq_pulse), .wr_err(wr_err)
    );

    function automatic bit exp_accept(bit we, int d, bit md, bit run);
        return we && (d != 0) && !(md && run);
    endfunction

    function automatic bit exp_event(bit uf, bit md, bit sel, bit pk, bit vl);
        if (!md) return uf;
        return uf && (sel ? vl : pk);
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare outputs
    task automatic step(string tag, bit rst, bit uf, bit md, bit sel, bit pk,
                        bit vl, bit run, bit we, int d);
        logic e_irq, e_err;
        bit acc, ev;
        @(negedge clk);
        rst_n = !rst; uf_strobe = uf; mode_qual = md; cond_sel = sel;
        at_peak = pk; at_valley = vl; timer_running = run;
        wr_en = we; wr_data = W'(d);
        @(posedge clk);
        #1;
        e_irq = 1'b0; e_err = 1'b0;
        if (rst) begin
            m_ratio = 1; m_cnt = 0;
        end else begin
            acc = exp_accept(we, d, md, run);
            ev  = exp_event(uf, md, sel, pk, vl);
            e_err = we && !acc;
            if (acc) begin
                m_ratio = d; m_cnt = 0;
            end else if (ev) begin
                if (m_cnt == m_ratio - 1) begin e_irq = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end
        end
        check(tag, "irq_pulse", irq_pulse, e_irq);
        check(tag, "wr_err", wr_err, e_err);
    endtask

    task automatic uf0(string tag, bit uf);
        step(tag, 0, uf, 0, 0, 0, 0, 1, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        // R1: reset state, then ratio 1 interrupts on every underflow
        for (int i = 0; i < 3; i++) step("R1", 1, 1, 0, 0, 0, 0, 1, 1, 5);
        for (int i = 0; i < 3; i++) uf0("R1", 1);
        // R5 / R2: ratio 3, underflows with gaps
        step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 3);
        for (int i = 0; i < 9; i++) uf0("R2", (i % 3) != 1);
        // R6: write with a coincident underflow swallows it
        step("R6", 0, 1, 0, 0, 0, 0, 0, 1, 4);
        for (int i = 0; i < 5; i++) uf0("R6", 1);
        // R10: plain-mode write while running is accepted
        step("R10", 0, 0, 0, 0, 0, 0, 1, 1, 2);
        // R7: qualified-mode write while running is rejected, event still counts
        step("R7", 0, 1, 1, 0, 1, 0, 1, 1, 5);
        step("R7", 0, 1, 1, 0, 1, 0, 1, 0, 0);
        step("R7", 0, 0, 1, 0, 1, 0, 1, 0, 0);
        // R8: zero write ignored in either mode
        step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8", 0, 0, 1, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) uf0("R8", 1);
        // R3: peak qualification, valley flag irrelevant
        step("R3", 0, 0, 1, 0, 0, 0, 0, 1, 2);
        for (int i = 0; i < 12; i++)
            step("R3", 0, 1, 1, 0, i[0], i[1], 1, 0, 0);
        // R4: valley qualification, peak flag irrelevant
        for (int i = 0; i < 12; i++)
            step("R4", 0, 1, 1, 1, i[1], i[0], 1, 0, 0);
        // R9: no events, no interrupt
        for (int i = 0; i < 6; i++) step("R9", 0, 0, 1, 0, 1, 1, 1, 0, 0);
        // Random mix covering R2/R3/R4/R5/R6/R7/R8
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom % 10) == 0;
            step("R2/R3/R4/R5/R6/R7/R8", 0, $urandom % 2, ($urandom % 3) == 0,
                 $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                 we, $urandom % 16);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule